// File: doc/BRIEF.md
# RC Discharge Time Measurement Controller

This block reads a single resistive sensor using nothing but two tristate-capable digital pins and a clock. A capacitor sits on one pin, the capacitor pin. The sensor resistance connects that node to a second pin, the sensor pin. When a measurement is requested, the controller first drives the capacitor pin high to charge the capacitor. The capacitor pin then floats, and the sensor pin pulls low, so the capacitor drains through the sensor. The controller counts clock cycles until the capacitor pin reads as a logic low.

The count grows with the sensor resistance, so the result is a time measurement in clock cycles. The input from the capacitor pin is synchronized before use. The fixed synchronizer delay is removed from the reported count. A discharge that never crosses the threshold before the counter fills ends with an overflow flag instead of a count.

The pad cells sit outside the block: each pin gets an output-enable and an output value, and the capacitor pin's input comes back as a raw asynchronous bit.

Top module: `rc_discharge_timer`

## Requirements
- R1: After reset, and whenever no measurement is running, both output enables are low. After reset, `done_o`, `overflow_o` and `result_o` are all 0.
- R2: A `start_i` high in an idle cycle begins a charge phase in the next cycle. The charge phase lasts exactly CHARGE_CYCLES cycles, with `cap_oe_o`=1, `cap_out_o`=1 and `sns_oe_o`=0.
- R3: After the charge phase there is exactly one cycle with both output enables low.
- R4: In the discharge phase, `cap_oe_o`=0, `sns_oe_o`=1 and `sns_out_o`=0 until the measurement ends. The two enables are never high together.
- R5: Take j as the number of discharge cycles, counted from the first, in which `cap_in_i` was sampled high before it was first sampled low. The measurement then reports `result_o`=j with `overflow_o`=0. `done_o` rises three cycles after the cycle in which the low was first sampled.
- R6: If the capacitor pin is already low before the discharge phase begins, the measurement ends in the first discharge cycle and reports 0 rather than a negative value.
- R7: If the pin is still high when the discharge counter reaches 2^CNT_W-1, the measurement ends with `overflow_o`=1 and `result_o` all ones. The largest valid count is 2^CNT_W-3.
- R8: `done_o` is a one-cycle pulse. `result_o` and `overflow_o` change only in a cycle where `done_o` is high, and hold their values until the next completed measurement.
- R9: A `start_i` during the charge, gap or discharge phase has no effect on the pin sequence or the result.
- R10: A `start_i` in the same cycle as `done_o` is accepted, because the block is already idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Measurement request, sampled only while idle |
| cap_in_i | input | 1 | Raw input from the capacitor pin |
| cap_oe_o | output | 1 | Output enable, capacitor pin |
| cap_out_o | output | 1 | Output value, capacitor pin |
| sns_oe_o | output | 1 | Output enable, sensor pin |
| sns_out_o | output | 1 | Output value, sensor pin |
| result_o | output | CNT_W | Discharge time in cycles, held |
| overflow_o | output | 1 | Last measurement overflowed, held |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CNT_W=5 and CHARGE_CYCLES=3. With these values the overflow point (a count of 31) and the largest valid count (29 cycles) can be reached in a few dozen cycles. The bench steps the crossing point across that boundary: 29 yields a valid count and 30 yields overflow. The short charge phase lets the bench place busy-time start requests in every phase. It also lets a new start coincide with the done pulse, so both are checked cheaply.

// File: rtl/rcdt_pkg.sv
package rcdt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_GAP    = 2'd2,
        PH_DISCH  = 2'd3
    } phase_e;

    typedef struct packed {
        logic cap_oe;
        logic cap_out;
        logic sns_oe;
        logic sns_out;
    } pin_ctl_t;

endpackage

// File: rtl/rcdt_sync.sv
module rcdt_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcdt_sequencer.sv
module rcdt_sequencer
    import rcdt_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int CHARGE_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             level_hi_i,
    output phase_e           phase_d_o,
    output logic             finish_o,
    output logic             ovf_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int CHG_W = (CHARGE_CYCLES > 1) ? $clog2(CHARGE_CYCLES) : 1;
    localparam logic [CHG_W-1:0] CHG_LAST = CHG_W'(CHARGE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

    typedef struct packed {
        phase_e           phase;
        logic [CHG_W-1:0] chg;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic finish_d, ovf_d;

    always_comb begin
        s_d      = s_q;
        finish_d = 1'b0;
        ovf_d    = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                s_d.chg = '0;
                s_d.cnt = '0;
                if (start_i) s_d.phase = PH_CHARGE;
            end
            PH_CHARGE: begin
                if (s_q.chg == CHG_LAST) begin
                    s_d.phase = PH_GAP;
                    s_d.chg   = '0;
                end else begin
                    s_d.chg = s_q.chg + 1'b1;
                end
            end
            PH_GAP: begin
                s_d.phase = PH_DISCH;
                s_d.cnt   = '0;
            end
            PH_DISCH: begin
                if (!level_hi_i) begin
                    finish_d  = 1'b1;
                    s_d.phase = PH_IDLE;
                end else if (s_q.cnt == CNT_TOP) begin
                    finish_d  = 1'b1;
                    ovf_d     = 1'b1;
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.chg   <= '0;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_d_o = s_d.phase;
    assign finish_o  = finish_d;
    assign ovf_o     = ovf_d;
    assign count_o   = s_q.cnt;
endmodule

// File: rtl/rcdt_pin_drive.sv
module rcdt_pin_drive
    import rcdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  phase_e   phase_d_i,
    output pin_ctl_t pins_o
);
    pin_ctl_t pins_d, pins_q;

    always_comb begin
        pins_d = '0;
        unique case (phase_d_i)
            PH_CHARGE: begin
                pins_d.cap_oe  = 1'b1;
                pins_d.cap_out = 1'b1;
            end
            PH_DISCH: begin
                pins_d.sns_oe  = 1'b1;
                pins_d.sns_out = 1'b0;
            end
            default: pins_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign pins_o = pins_q;
endmodule

// File: rtl/rcdt_result.sv
module rcdt_result #(
    parameter int CNT_W   = 16,
    parameter int LATENCY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             finish_i,
    input  logic             ovf_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] result_o,
    output logic             ovf_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LATENCY);

    typedef struct packed {
        logic [CNT_W-1:0] res;
        logic             ovf;
        logic             done;
    } res_t;

    res_t r_d, r_q;
    logic [CNT_W-1:0] trimmed;

    always_comb begin
        trimmed  = (count_i >= LAT_C) ? (count_i - LAT_C) : '0;
        r_d      = r_q;
        r_d.done = finish_i;
        if (finish_i) begin
            r_d.ovf = ovf_i;
            r_d.res = ovf_i ? {CNT_W{1'b1}} : trimmed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result_o = r_q.res;
    assign ovf_o    = r_q.ovf;
    assign done_o   = r_q.done;
endmodule

// File: rtl/rc_discharge_timer.sv
module rc_discharge_timer
    import rcdt_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int CHARGE_CYCLES = 1000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cap_in_i,
    output logic             cap_oe_o,
    output logic             cap_out_o,
    output logic             sns_oe_o,
    output logic             sns_out_o,
    output logic [CNT_W-1:0] result_o,
    output logic             overflow_o,
    output logic             done_o
);
    phase_e           phase_d;
    logic             level_hi, finish, ovf;
    logic [CNT_W-1:0] count;
    pin_ctl_t         pins;

    rcdt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(cap_in_i), .sync_o(level_hi)
    );

    rcdt_sequencer #(.CNT_W(CNT_W), .CHARGE_CYCLES(CHARGE_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_hi_i(level_hi),
        .phase_d_o(phase_d), .finish_o(finish), .ovf_o(ovf), .count_o(count)
    );

    rcdt_pin_drive u_pins (
        .clk(clk), .rst_n(rst_n), .phase_d_i(phase_d), .pins_o(pins)
    );

    rcdt_result #(.CNT_W(CNT_W), .LATENCY(SYNC_STAGES)) u_res (
        .clk(clk), .rst_n(rst_n), .finish_i(finish), .ovf_i(ovf),
        .count_i(count), .result_o(result_o), .ovf_o(overflow_o), .done_o(done_o)
    );

    assign cap_oe_o  = pins.cap_oe;
    assign cap_out_o = pins.cap_out;
    assign sns_oe_o  = pins.sns_oe;
    assign sns_out_o = pins.sns_out;
endmodule

// File: rtl/rcdt_checker.sv
module rcdt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_oe_o,
    input logic             cap_out_o,
    input logic             sns_oe_o,
    input logic             sns_out_o,
    input logic [CNT_W-1:0] result_o,
    input logic             overflow_o,
    input logic             done_o
);
    // R4: the two pins never drive together
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_oe_o && sns_oe_o));

    // R2: the capacitor pin drives only high
    p_charge_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_oe_o |-> cap_out_o);

    // R4: the sensor pin drives only low
    p_sense_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sns_oe_o |-> !sns_out_o);

    // R3: the end of charge is followed by a cycle with both pins floating
    p_gap_after_charge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_oe_o) |-> !sns_oe_o);

    // R3: discharge never begins straight after a driven capacitor pin
    p_gap_before_disch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sns_oe_o) |-> $past(!cap_oe_o));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: result and flag move only with done
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(overflow_o)));

    // R7: overflow reports an all-ones count
    p_ovf_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && overflow_o) |-> (result_o == {CNT_W{1'b1}}));

    // R1: completion leaves both pins floating
    p_idle_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cap_oe_o && !sns_oe_o));
endmodule

bind rc_discharge_timer rcdt_checker #(.CNT_W(CNT_W)) u_rcdt_checker (
    .clk(clk), .rst_n(rst_n),
    .cap_oe_o(cap_oe_o), .cap_out_o(cap_out_o),
    .sns_oe_o(sns_oe_o), .sns_out_o(sns_out_o),
    .result_o(result_o), .overflow_o(overflow_o), .done_o(done_o)
);

// File: tb/rc_discharge_timer_test.sv
`timescale 1ns/1ps
module rc_discharge_timer_test;
    localparam int W   = 5;
    localparam int CHG = 3;
    localparam int TOP = (1 << W) - 1;
    localparam int LAT = 2;
    localparam int FAR = 32'h3fffffff;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cap_in_i = 1'b1;
    logic cap_oe_o, cap_out_o, sns_oe_o, sns_out_o, overflow_o, done_o;
    logic [W-1:0] result_o;

    always #5 clk = ~clk;

    rc_discharge_timer #(.CNT_W(W), .CHARGE_CYCLES(CHG), .SYNC_STAGES(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cap_in_i(cap_in_i),
        .cap_oe_o(cap_oe_o), .cap_out_o(cap_out_o), .sns_oe_o(sns_oe_o),
        .sns_out_o(sns_out_o), .result_o(result_o), .overflow_o(overflow_o),
        .done_o(done_o)
    );

    typedef struct {
        bit    c_oe;
        bit    c_out;
        bit    s_oe;
        bit    done;
        bit    ovf;
        int    res;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    low_at = FAR;
    int    held_res = 0;
    bit    held_ovf = 1'b0;
    string note = "";
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s%s %s cycle %0d: actual=%0d expected=%0d",
                     tag, note, what, cyc, act, exp);
        end
    endtask

    task automatic compare();
        exp_t e;
        string rtag;
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.c_oe = 0; e.c_out = 0; e.s_oe = 0; e.done = 0;
            e.ovf = 0; e.res = 0; e.tag = "R1";
        end
        rtag = "R8";
        if (e.done) begin
            held_res = e.res;
            held_ovf = e.ovf;
            rtag = e.tag;
        end
        check({cap_oe_o, cap_out_o, sns_oe_o, sns_out_o} == {e.c_oe, e.c_out, e.s_oe, 1'b0},
              e.tag, "pins", {cap_oe_o, cap_out_o, sns_oe_o, sns_out_o},
              {e.c_oe, e.c_out, e.s_oe, 1'b0});
        check(done_o == e.done, e.tag, "done", done_o, e.done);
        check(result_o == W'(held_res) && overflow_o == held_ovf, rtag,
              "result/ovf", {overflow_o, result_o}, {held_ovf, W'(held_res)});
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        start_i  = 1'b0;
        cap_in_i = (cyc >= low_at) ? 1'b0 : 1'b1;
    endtask

    // Queue the expected pin sequence for one measurement, requested in this cycle.
    task automatic launch(int j, bit stuck, string tag);
        exp_t e;
        int t, disch, res;
        bit ovf;
        t = cyc;
        start_i = 1'b1;
        low_at  = stuck ? t : t + CHG + 2 + j;
        cap_in_i = (cyc >= low_at) ? 1'b0 : 1'b1;
        if (stuck) begin
            disch = 1; res = 0; ovf = 0;
        end else if (j + LAT <= TOP) begin
            disch = j + LAT + 1; res = j; ovf = 0;
        end else begin
            disch = TOP + 1; res = TOP; ovf = 1;
        end
        e.done = 0; e.ovf = 0; e.res = 0;
        for (int k = 0; k < CHG; k++) begin
            e.c_oe = 1; e.c_out = 1; e.s_oe = 0; e.tag = "R2"; q.push_back(e);
        end
        e.c_oe = 0; e.c_out = 0; e.s_oe = 0; e.tag = "R3"; q.push_back(e);
        for (int k = 0; k < disch; k++) begin
            e.s_oe = 1; e.tag = "R4"; q.push_back(e);
        end
        e.s_oe = 0; e.done = 1; e.res = res; e.ovf = ovf; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain(int poke_at);
        int k;
        k = 0;
        while (q.size() > 0) begin
            tick();
            if (k == poke_at || k == poke_at + 4 || k == poke_at + 9)
                start_i = 1'b1;
            k++;
        end
        low_at = FAR;
    endtask

    task automatic measure(int j, bit stuck, string tag);
        tick();
        launch(j, stuck, tag);
        drain(-100);
        low_at = FAR;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle pins
        repeat (3) tick();

        measure(0, 0, "R5");          // R5: immediate crossing
        measure(5, 0, "R5");
        measure(12, 0, "R5");
        measure(TOP - 2, 0, "R7");    // R7: largest valid count
        measure(TOP - 1, 0, "R7");    // R7: first overflowing case
        measure(100, 0, "R7");
        measure(0, 1, "R6");          // R6: pin low before discharge
        repeat (2) tick();

        // R9: start requests in charge, gap and discharge are ignored
        note = " R9";
        tick();
        launch(7, 0, "R9");
        drain(0);
        repeat (4) tick();
        note = "";

        // R10: a start together with done is taken at once
        tick();
        launch(3, 0, "R5");
        drain(-100);
        launch(9, 0, "R10");
        drain(-100);
        repeat (3) tick();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule